// File: doc/BRIEF.md
# Interleaved Line Refill Controller

This controller fills one four-word cache line from a main memory that is divided into four banks, each able to accept its own read. The cache presents a line address with a one-cycle request strobe. The controller then reads the four words of that line, one from each bank, and returns them to the cache over a bus one word wide. Each word comes back with a valid strobe, and a last flag marks the final word. A cycle counter reports how long the current fill has taken.

Every bank read has a fixed cost. One cycle carries the address, the bank then needs fifteen cycles, and one more cycle brings the word back. In the overlapped mode the controller addresses the four banks on four consecutive cycles. Their access times therefore run side by side, and the words reach the cache back-to-back, so a fill takes 1 + 15 + 4 = 20 cycles. In the sequential mode, which is kept for comparison, a word is requested only after the previous word has been returned. Each word then costs the full 17 cycles, and a fill takes 68 cycles. The mode is sampled when a request is accepted and is fixed for the duration of that fill.

Bank port model: the controller raises one bank's enable for a single cycle A and drives that bank's address during A. The bank presents the word on its data lane in cycle A + BANK_LAT and at no other time. The controller registers that word onto the response bus, where it appears in cycle A + BANK_LAT + 1.

Top module: `line_refill_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, rsp_valid, rsp_last and every bank enable are 0, and fill_cycles is 0.
- R2: A request is accepted only when the controller is idle. A request raised while busy has no effect. The current fill keeps its data and its timing, and no extra fill, bank read or word follows it.
- R3: Word w of a line (w = 0..3, the two low bits of the word address) is read from bank w, using the line address as the address within that bank. The data returned as word w is the data that bank w presented for that read.
- R4: In overlapped mode (req_overlap = 1), with the accept edge ending cycle 0, bank w is enabled in cycle 1 + w only. Word w appears on the response bus in cycle 17 + w, so the last word appears in cycle 20.
- R5: In sequential mode (req_overlap = 0), bank w is enabled in cycle 1 + 17·w only. Word w appears in cycle 17·(w + 1), so the last word appears in cycle 68.
- R6: Words are delivered in the order 0, 1, 2, 3, one per rsp_valid cycle. rsp_last is 1 with word 3 and 0 with every other word.
- R7: busy is 1 from cycle 1 through the cycle that carries the last word. done is a one-cycle pulse in the following cycle, and busy is 0 in that cycle.
- R8: fill_cycles is 1 in cycle 1 and rises by one in each busy cycle. After the fill ends it holds the total (20 in overlapped mode, 68 in sequential mode) until the next request is accepted.
- R9: At most one bank enable is high in any cycle.
- R10: A request presented in the done cycle is accepted, so fills can follow one another with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request strobe, sampled while idle |
| req_line | input | LINE_AW | Line address of the fill |
| req_overlap | input | 1 | 1 = overlapped bank access, 0 = sequential |
| busy | output | 1 | High while a fill is in progress |
| done | output | 1 | One-cycle pulse after the last word |
| rsp_valid | output | 1 | A line word is on rsp_data |
| rsp_data | output | DATA_W | Returned line word |
| rsp_last | output | 1 | Marks word 3 of the line |
| fill_cycles | output | CNT_W | Cycle count of the current or most recent fill |
| bank_rd_en | output | 4 | One read enable per bank |
| bank_rd_addr | output | 4·LINE_AW | Per-bank read address, bank b in slice b |
| bank_rd_data | input | 4·DATA_W | Per-bank read data, bank b in slice b |

## Verification
The bound checker watches every cycle for the following properties. No more than one bank is addressed at once, and no bank is addressed while the controller is idle. In overlapped mode the enables step from bank to bank on consecutive cycles. In sequential mode no bank is addressed in a cycle that returns a word, and the next bank is addressed right after a returned word that is not the last. Responses appear only while busy, the last word is always followed by the done pulse, and the counter steps by one while busy and holds while idle. Only the bench scenarios can show the following. The exact cycles 20 and 68, and the absolute position of every enable. That each word carries its own bank's data for the requested line. That a request made in the middle of a fill leaves no trace, and that a fill starts back-to-back in the done cycle.

// File: rtl/refill_pkg.sv
package refill_pkg;

    // Four banks; word w of a line lives in bank w.
    localparam int N_BANKS = 4;
    localparam int BIDX_W  = $clog2(N_BANKS);
    localparam int PTR_W   = BIDX_W + 1;

    typedef enum logic {
        MODE_SERIAL  = 1'b0,
        MODE_OVERLAP = 1'b1
    } fill_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    // Tag of a bank read still waiting out the bank latency.
    typedef struct packed {
        logic              vld;
        logic [BIDX_W-1:0] word;
    } inflight_t;

    function automatic logic word_is_last(input logic [BIDX_W-1:0] w);
        return w == BIDX_W'(N_BANKS - 1);
    endfunction

    function automatic logic [N_BANKS-1:0] bank_select(input logic vld,
                                                       input logic [BIDX_W-1:0] w);
        return vld ? (N_BANKS'(1) << w) : '0;
    endfunction

endpackage

// File: rtl/refill_issue.sv
module refill_issue
    import refill_pkg::*;
#(
    parameter int LINE_AW = 10,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [LINE_AW-1:0] req_line,
    input  logic               req_overlap,
    input  logic               rsp_valid,
    input  logic               rsp_last,
    output logic               busy,
    output logic               done,
    output logic               issue_vld,
    output logic [BIDX_W-1:0]  issue_word,
    output logic [LINE_AW-1:0] line_q,
    output logic               overlap_q,
    output logic [CNT_W-1:0]   fill_cycles
);

    fill_state_e      state_q;
    fill_mode_e       mode_q;
    logic [PTR_W-1:0] ptr_q;
    logic             ready_q;   // sequential mode: previous word returned
    logic             fill_end;

    assign fill_end   = rsp_valid && rsp_last;
    assign busy       = (state_q == ST_RUN);
    assign overlap_q  = (mode_q == MODE_OVERLAP);
    assign issue_word = ptr_q[BIDX_W-1:0];
    assign issue_vld  = busy && (ptr_q < PTR_W'(N_BANKS))
                        && (overlap_q || ready_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_SERIAL;
            line_q      <= '0;
            ptr_q       <= '0;
            ready_q     <= 1'b0;
            done        <= 1'b0;
            fill_cycles <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q     <= ST_RUN;
                        mode_q      <= req_overlap ? MODE_OVERLAP : MODE_SERIAL;
                        line_q      <= req_line;
                        ptr_q       <= '0;
                        ready_q     <= 1'b1;
                        fill_cycles <= CNT_W'(1);
                    end
                end
                default: begin
                    if (!fill_end) begin
                        fill_cycles <= fill_cycles + CNT_W'(1);
                    end
                    if (issue_vld) begin
                        ptr_q   <= ptr_q + PTR_W'(1);
                        ready_q <= 1'b0;
                    end
                    if (rsp_valid && !rsp_last) begin
                        ready_q <= 1'b1;
                    end
                    if (fill_end) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/refill_lat_pipe.sv
module refill_lat_pipe
    import refill_pkg::*;
#(
    parameter int BANK_LAT = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  inflight_t tag_in,
    output inflight_t tag_out
);

    inflight_t stage_q [BANK_LAT];

    for (genvar i = 0; i < BANK_LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= '0;
            end else if (i == 0) begin
                stage_q[i] <= tag_in;
            end else begin
                stage_q[i] <= stage_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    // Visible BANK_LAT cycles after the address cycle, aligned with bank data.
    assign tag_out = stage_q[BANK_LAT-1];

endmodule

// File: rtl/refill_return.sv
module refill_return
    import refill_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  inflight_t                 tag,
    input  logic [N_BANKS*DATA_W-1:0] bank_rd_data,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      rsp_last
);

    logic [DATA_W-1:0] lane [N_BANKS];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_lane
        assign lane[b] = bank_rd_data[b*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
        end else begin
            rsp_valid <= tag.vld;
            rsp_last  <= tag.vld && word_is_last(tag.word);
            if (tag.vld) begin
                rsp_data <= lane[tag.word];
            end
        end
    end

endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
    import refill_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LINE_AW  = 10,
    parameter int BANK_LAT = 15,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [LINE_AW-1:0]         req_line,
    input  logic                       req_overlap,
    output logic                       busy,
    output logic                       done,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_data,
    output logic                       rsp_last,
    output logic [CNT_W-1:0]           fill_cycles,
    output logic [N_BANKS-1:0]         bank_rd_en,
    output logic [N_BANKS*LINE_AW-1:0] bank_rd_addr,
    input  logic [N_BANKS*DATA_W-1:0]  bank_rd_data
);

    logic               issue_vld;
    logic [BIDX_W-1:0]  issue_word;
    logic [LINE_AW-1:0] line_q;
    logic               overlap_q;
    inflight_t          tag_issue;
    inflight_t          tag_due;

    refill_issue #(
        .LINE_AW (LINE_AW),
        .CNT_W   (CNT_W)
    ) u_issue (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_line    (req_line),
        .req_overlap (req_overlap),
        .rsp_valid   (rsp_valid),
        .rsp_last    (rsp_last),
        .busy        (busy),
        .done        (done),
        .issue_vld   (issue_vld),
        .issue_word  (issue_word),
        .line_q      (line_q),
        .overlap_q   (overlap_q),
        .fill_cycles (fill_cycles)
    );

    assign tag_issue = '{vld: issue_vld, word: issue_word};
    assign bank_rd_en = bank_select(issue_vld, issue_word);

    // The in-bank address of every word is the line address.
    for (genvar b = 0; b < N_BANKS; b++) begin : g_addr
        assign bank_rd_addr[b*LINE_AW +: LINE_AW] = line_q;
    end

    refill_lat_pipe #(
        .BANK_LAT (BANK_LAT)
    ) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .tag_in  (tag_issue),
        .tag_out (tag_due)
    );

    refill_return #(
        .DATA_W (DATA_W)
    ) u_return (
        .clk          (clk),
        .rst          (rst),
        .tag          (tag_due),
        .bank_rd_data (bank_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_last     (rsp_last)
    );

endmodule

// File: rtl/line_refill_chk.sv
module line_refill_chk
    import refill_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               rsp_valid,
    input logic               rsp_last,
    input logic [N_BANKS-1:0] bank_rd_en,
    input logic               overlap,
    input logic [CNT_W-1:0]   fill_cycles
);

    // R9
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_rd_en));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bank_rd_en == '0 && !rsp_valid));

    // R7
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_last) |=> (done && !busy));

    // R7
    done_needs_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rsp_valid && rsp_last));

    // R6
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    // R4
    overlap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (overlap && bank_rd_en != '0 && !bank_rd_en[N_BANKS-1])
        |=> (bank_rd_en == ($past(bank_rd_en) << 1)));

    // R5
    serial_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !overlap && rsp_valid) |-> (bank_rd_en == '0));

    // R5
    serial_next_chk: assert property (@(posedge clk) disable iff (rst)
        (!overlap && rsp_valid && !rsp_last) |=> (bank_rd_en != '0));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (fill_cycles == $past(fill_cycles) + CNT_W'(1)));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(fill_cycles));

endmodule

bind line_refill_ctrl line_refill_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .rsp_valid   (rsp_valid),
    .rsp_last    (rsp_last),
    .bank_rd_en  (bank_rd_en),
    .overlap     (overlap_q),
    .fill_cycles (fill_cycles)
);

// File: tb/line_refill_ctrl_bench.sv
`timescale 1ns/100ps
module line_refill_ctrl_bench;

    localparam int DW   = 32;
    localparam int LAW  = 10;
    localparam int LAT  = 15;
    localparam int CW   = 8;
    localparam int NB   = 4;
    localparam int STEP = LAT + 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [LAW-1:0]     req_line = '0;
    logic               req_overlap = 1'b0;
    logic               busy, done, rsp_valid, rsp_last;
    logic [DW-1:0]      rsp_data;
    logic [CW-1:0]      fill_cycles;
    logic [NB-1:0]      bank_rd_en;
    logic [NB*LAW-1:0]  bank_rd_addr;
    logic [NB*DW-1:0]   bank_rd_data;

    always #2.5 clk = ~clk;

    line_refill_ctrl #(
        .DATA_W (DW), .LINE_AW (LAW), .BANK_LAT (LAT), .CNT_W (CW)
    ) u_line_refill_ctrl (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_line (req_line),
        .req_overlap (req_overlap), .busy (busy), .done (done),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_last (rsp_last),
        .fill_cycles (fill_cycles), .bank_rd_en (bank_rd_en),
        .bank_rd_addr (bank_rd_addr), .bank_rd_data (bank_rd_data)
    );

    function automatic logic [DW-1:0] bank_word(input int b, input logic [LAW-1:0] a);
        return 32'hB000_0000 | (32'(b) << 24) | 32'(a);
    endfunction

    // Fixed-latency bank model: word visible exactly LAT cycles after its address cycle.
    logic [NB-1:0]     en_pipe [LAT];
    logic [NB*LAW-1:0] ad_pipe [LAT];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                en_pipe[i] <= '0;
                ad_pipe[i] <= '0;
            end
        end else begin
            en_pipe[0] <= bank_rd_en;
            ad_pipe[0] <= bank_rd_addr;
            for (int i = 1; i < LAT; i++) begin
                en_pipe[i] <= en_pipe[i-1];
                ad_pipe[i] <= ad_pipe[i-1];
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_rd_data[b*DW +: DW] = (en_pipe[LAT-1][b] === 1'b1)
                ? bank_word(b, ad_pipe[LAT-1][b*LAW +: LAW])
                : (32'hDEAD_0000 | 32'(b));
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_err    = 0;
    int t0       = 0;

    typedef struct {
        logic [DW-1:0] data;
        logic          last;
        int            rel;
        string         rq;
    } exp_t;
    exp_t exq[$];

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pop and compare each returned word.
    always @(negedge clk) begin
        exp_t e;
        if (!rst && rsp_valid === 1'b1) begin
            if (exq.size() == 0) begin
                check(0, "R2", "unexpected word", rsp_data, 0);
            end else begin
                e = exq.pop_front();
                check(rsp_data == e.data, "R3", "word data", rsp_data, e.data);
                check(rsp_last == e.last, "R6", "last flag", rsp_last, e.last);
                check(cyc - t0 == e.rel, e.rq, "word cycle", cyc - t0, e.rel);
            end
        end
    end

    // Driver: called at a negedge; returns at the negedge of the done cycle.
    task automatic run_fill(input logic [LAW-1:0] line, input bit overlap,
                            input bit poke, input string start_rq);
        int total = overlap ? (1 + LAT + NB) : (NB * STEP);
        int rel;
        int mism  = 0;
        int multi = 0;
        int bmis  = 0;
        logic [NB-1:0] exp_en;
        for (int w = 0; w < NB; w++) begin
            exp_t e;
            e.data = bank_word(w, line);
            e.last = (w == NB - 1);
            e.rel  = overlap ? (STEP + w) : ((w + 1) * STEP);
            e.rq   = overlap ? "R4" : "R5";
            exq.push_back(e);
        end
        req_valid   = 1'b1;
        req_line    = line;
        req_overlap = overlap;
        t0          = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        rel = 1;
        check(busy == 1'b1, start_rq, "busy in cycle 1", busy, 1);
        check(done == 1'b0, "R7", "done low in cycle 1", done, 0);
        check(fill_cycles == CW'(1), "R8", "counter in cycle 1", fill_cycles, 1);
        while (done !== 1'b1 && rel <= total + 5) begin
            exp_en = '0;
            if (overlap) begin
                if (rel <= NB) exp_en = NB'(1) << (rel - 1);
            end else if ((rel - 1) % STEP == 0 && (rel - 1) / STEP < NB) begin
                exp_en = NB'(1) << ((rel - 1) / STEP);
            end
            if (bank_rd_en !== exp_en) mism++;
            if ($countones(bank_rd_en) > 1) multi++;
            if (busy !== 1'b1) bmis++;
            if (poke && rel == 5) begin
                req_valid   = 1'b1;
                req_line    = ~line;
                req_overlap = ~overlap;
            end
            if (poke && rel == 6) req_valid = 1'b0;
            @(negedge clk);
            rel++;
        end
        req_valid = 1'b0;
        check(rel == total + 1, "R7", "done cycle", rel, total + 1);
        check(mism == 0, overlap ? "R4" : "R5", "bank enable cycles", mism, 0);
        check(multi == 0, "R9", "multiple enables", multi, 0);
        check(bmis == 0, "R7", "busy during fill", bmis, 0);
        check(busy == 1'b0, "R7", "busy in done cycle", busy, 0);
        check(fill_cycles == CW'(total), "R8", "fill total", fill_cycles, total);
        check(exq.size() == 0, "R6", "words outstanding", exq.size(), 0);
    endtask

    task automatic quiet(input int n, input logic [CW-1:0] held);
        int mis = 0;
        repeat (n) begin
            @(negedge clk);
            if (busy !== 1'b0 || done !== 1'b0 || rsp_valid !== 1'b0 ||
                bank_rd_en !== '0) mis++;
            if (fill_cycles !== held) mis++;
        end
        check(mis == 0, "R2", "idle activity or counter change", mis, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 0 && done == 0 && rsp_valid == 0 && rsp_last == 0,
              "R1", "flags in reset", {busy, done, rsp_valid, rsp_last}, 0);
        check(bank_rd_en == '0, "R1", "enables in reset", bank_rd_en, 0);
        check(fill_cycles == '0, "R1", "counter in reset", fill_cycles, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && bank_rd_en == '0, "R1",
              "state after reset", {busy, done, bank_rd_en}, 0);

        run_fill(10'h012, 1'b1, 1'b0, "R7");
        quiet(5, CW'(20));
        run_fill(10'h3A5, 1'b0, 1'b0, "R7");
        quiet(3, CW'(68));
        run_fill(10'h0C3, 1'b1, 1'b1, "R2");
        quiet(25, CW'(20));
        run_fill(10'h155, 1'b1, 1'b0, "R7");
        run_fill(10'h2AA, 1'b0, 1'b0, "R10");
        run_fill(10'h3FF, 1'b1, 1'b0, "R10");
        run_fill(10'h000, 1'b0, 1'b1, "R10");
        quiet(20, CW'(68));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule